// File: doc/BRIEF.md
# Self-Move Hint and No-Op Classifier

This block sits just behind instruction decode and looks at every instruction of the bitwise-OR class. Most such instructions are ordinary work, but a few encodings that change no architectural state carry side meanings. The OR-immediate of register 0 into register 0 with a zero immediate is the designated no-op. A register-form OR whose destination and both sources name the same register, from a small fixed set, is a request to change the running thread's priority.

The block turns each valid instruction into exactly one registered one-cycle result: a no-op flag, a priority-hint strobe with a 3-bit level, or a plain flag meaning "execute normally". The last requested level is held on its output until a newer hint arrives. A privilege input drops the levels reserved for the kernel while the core runs in user mode. Such a dropped request still executes as an ordinary move. The scheduler that acts on the level is downstream.

Inputs arrive already split into fields. `in_kind` uses 2'b01 for register-form OR, 2'b10 for OR-immediate, and any other value for an instruction outside the class. `in_rec` marks the form that also writes the condition field. Results appear one clock after the instruction is presented.

Top module: `prio_hint_dec`

## Requirements
- R1: During reset and after it, with no input, `nop_o`, `plain_o` and `hint_vld_o` are 0 and `hint_lvl_o` is 3 (normal).
- R2: A valid OR-immediate (kind 2'b10) with destination 0, source 0 and immediate 0 raises `nop_o` for one cycle. Any other OR-immediate raises `plain_o` instead.
- R3: A valid register-form OR (kind 2'b01, `in_rec`=0) with destination and both sources all equal to 1 raises `hint_vld_o` with level 1 (low).
- R4: The same self-move on register 6 gives level 2 (medium-low).
- R5: The same self-move on register 2 gives level 3 (normal).
- R6: `hint_vld_o` lasts one cycle per hint, and `hint_lvl_o` keeps the last accepted level until the next accepted hint.
- R7: With `user_mode`=0, self-moves on register 5, 3 and 7 give levels 4, 5 and 6. With `user_mode`=1 they raise `plain_o`, raise no strobe and leave `hint_lvl_o` unchanged.
- R8: A self-move with `in_rec`=1 raises `plain_o` and never a hint.
- R9: A self-move on any register outside {1,2,3,5,6,7}, a register-form OR with differing registers, and any kind outside the class all raise `plain_o`.
- R10: Each valid instruction produces exactly one of `nop_o`, `plain_o`, `hint_vld_o` on the next cycle, and a cycle without `in_vld` produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| in_vld | input | 1 | An instruction is presented this cycle |
| in_kind | input | 2 | 01 register-form OR, 10 OR-immediate, other: not in class |
| in_rec | input | 1 | Record form that writes the condition field |
| in_rt | input | 5 | Destination register index |
| in_ra | input | 5 | First source register index |
| in_rb | input | 5 | Second source register index (register form) |
| in_imm | input | 16 | Immediate (OR-immediate form) |
| user_mode | input | 1 | 1 when the core runs in user mode |
| nop_o | output | 1 | Designated no-op seen |
| plain_o | output | 1 | Instruction executes normally |
| hint_vld_o | output | 1 | One-cycle strobe for an accepted priority hint |
| hint_lvl_o | output | 3 | Last accepted priority level |

## Verification
The assertions assume that `in_kind`, the register fields, `in_imm` and `user_mode` are settled whenever `in_vld` is sampled high. They also assume that `in_vld` is a plain per-cycle qualifier with no handshake. The bench changes every input only on the falling clock edge and lowers `in_vld` between instructions. The idle-cycle and single-result properties therefore see each instruction in isolation. Fields not used by a form are still driven to defined values, so the kind decode is what separates the classes.

// File: rtl/prio_hint_pkg.sv
package prio_hint_pkg;

  localparam int REGW = 5;
  localparam int IMMW = 16;
  localparam int LVLW = 3;

  typedef enum logic [1:0] {
    K_OTHER  = 2'b00,
    K_OR_REG = 2'b01,
    K_OR_IMM = 2'b10,
    K_RSVD   = 2'b11
  } op_kind_e;

  localparam logic [LVLW-1:0] LV_LOW     = 3'd1;
  localparam logic [LVLW-1:0] LV_MEDLOW  = 3'd2;
  localparam logic [LVLW-1:0] LV_NORMAL  = 3'd3;
  localparam logic [LVLW-1:0] LV_MEDHIGH = 3'd4;
  localparam logic [LVLW-1:0] LV_HIGH    = 3'd5;
  localparam logic [LVLW-1:0] LV_TOP     = 3'd6;

  typedef struct packed {
    logic            hit;
    logic            kern;
    logic [LVLW-1:0] lvl;
  } map_t;

  // Fixed register-to-level table for self-move hints.
  function automatic map_t reg_map(input logic [REGW-1:0] r);
    map_t m;
    m = '{hit: 1'b0, kern: 1'b0, lvl: LV_NORMAL};
    case (r)
      5'd1: m = '{hit: 1'b1, kern: 1'b0, lvl: LV_LOW};
      5'd6: m = '{hit: 1'b1, kern: 1'b0, lvl: LV_MEDLOW};
      5'd2: m = '{hit: 1'b1, kern: 1'b0, lvl: LV_NORMAL};
      5'd5: m = '{hit: 1'b1, kern: 1'b1, lvl: LV_MEDHIGH};
      5'd3: m = '{hit: 1'b1, kern: 1'b1, lvl: LV_HIGH};
      5'd7: m = '{hit: 1'b1, kern: 1'b1, lvl: LV_TOP};
      default: ;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/prio_hint_rst_sync.sv
module prio_hint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/prio_hint_classify.sv
module prio_hint_classify
  import prio_hint_pkg::*;
(
  input  op_kind_e        kind,
  input  logic            rec,
  input  logic [REGW-1:0] rt,
  input  logic [REGW-1:0] ra,
  input  logic [REGW-1:0] rb,
  input  logic [IMMW-1:0] imm,
  output logic            is_nop,
  output logic            is_hint,
  output logic            is_kern,
  output logic [LVLW-1:0] lvl
);
  map_t m;
  logic self_move;

  always_comb begin
    m         = reg_map(ra);
    self_move = (rt == ra) && (ra == rb);
    is_nop    = (kind == K_OR_IMM) && (rt == '0) && (ra == '0) && (imm == '0);
    // Record form writes the condition field, so it is real work.
    is_hint   = (kind == K_OR_REG) && !rec && self_move && m.hit;
    is_kern   = m.kern;
    lvl       = m.lvl;
  end
endmodule

// File: rtl/prio_hint_filter.sv
module prio_hint_filter (
  input  logic is_hint,
  input  logic is_kern,
  input  logic user_mode,
  output logic take_hint
);
  always_comb take_hint = is_hint && !(is_kern && user_mode);
endmodule

// File: rtl/prio_hint_outreg.sv
module prio_hint_outreg
  import prio_hint_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld,
  input  logic            is_nop,
  input  logic            take_hint,
  input  logic [LVLW-1:0] lvl,
  output logic            nop_q,
  output logic            plain_q,
  output logic            hint_vld_q,
  output logic [LVLW-1:0] lvl_q
);
  logic            nop_d, plain_d, hint_vld_d, lvl_en;
  logic [LVLW-1:0] lvl_d;

  always_comb begin
    nop_d      = vld && is_nop;
    hint_vld_d = vld && take_hint;
    plain_d    = vld && !is_nop && !take_hint;
    lvl_en     = hint_vld_d;
    lvl_d      = lvl_en ? lvl : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nop_q      <= 1'b0;
      plain_q    <= 1'b0;
      hint_vld_q <= 1'b0;
      lvl_q      <= LV_NORMAL;
    end else begin
      nop_q      <= nop_d;
      plain_q    <= plain_d;
      hint_vld_q <= hint_vld_d;
      lvl_q      <= lvl_d;
    end
  end

  // R6: level only moves together with the strobe
  a_r6_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hint_vld_q |-> $stable(lvl_q));

  // R10: results are mutually exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nop_q, plain_q, hint_vld_q}));
endmodule

// File: rtl/prio_hint_dec.sv
module prio_hint_dec
  import prio_hint_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [1:0]      in_kind,
  input  logic            in_rec,
  input  logic [REGW-1:0] in_rt,
  input  logic [REGW-1:0] in_ra,
  input  logic [REGW-1:0] in_rb,
  input  logic [IMMW-1:0] in_imm,
  input  logic            user_mode,
  output logic            nop_o,
  output logic            plain_o,
  output logic            hint_vld_o,
  output logic [LVLW-1:0] hint_lvl_o
);
  logic            rst_sync_n;
  logic            is_nop, is_hint, is_kern, take_hint;
  logic [LVLW-1:0] cls_lvl;

  prio_hint_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  prio_hint_classify u_cls (
    .kind(op_kind_e'(in_kind)), .rec(in_rec), .rt(in_rt), .ra(in_ra),
    .rb(in_rb), .imm(in_imm), .is_nop(is_nop), .is_hint(is_hint),
    .is_kern(is_kern), .lvl(cls_lvl));

  prio_hint_filter u_flt (
    .is_hint(is_hint), .is_kern(is_kern), .user_mode(user_mode),
    .take_hint(take_hint));

  prio_hint_outreg u_out (
    .clk(clk), .rst_n(rst_sync_n), .vld(in_vld), .is_nop(is_nop),
    .take_hint(take_hint), .lvl(cls_lvl), .nop_q(nop_o), .plain_q(plain_o),
    .hint_vld_q(hint_vld_o), .lvl_q(hint_lvl_o));

  // R10: one result per valid instruction, none when idle
  a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_vld |=> $onehot({nop_o, plain_o, hint_vld_o}));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_vld |=> !(nop_o || plain_o || hint_vld_o));

  // R7: user mode never yields a kernel-only level
  a_r7_user_filter: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && user_mode) |=> !(hint_vld_o && (hint_lvl_o > LV_NORMAL)));

  // R8: record form never hints
  a_r8_rec_plain: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_vld && in_rec) |=> !hint_vld_o);

  // R2: no-op flag only after a zero immediate
  a_r2_nop_imm: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nop_o |-> ($past(in_imm) == '0));
endmodule

// File: tb/test_prio_hint_dec.sv
module test_prio_hint_dec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld, in_rec, user_mode;
  logic [1:0]  in_kind;
  logic [4:0]  in_rt, in_ra, in_rb;
  logic [15:0] in_imm;
  logic        nop_o, plain_o, hint_vld_o;
  logic [2:0]  hint_lvl_o;

  int total = 0;
  int bad   = 0;
  logic [2:0] cur_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_hint_dec i_prio_hint_dec (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_kind(in_kind),
    .in_rec(in_rec), .in_rt(in_rt), .in_ra(in_ra), .in_rb(in_rb),
    .in_imm(in_imm), .user_mode(user_mode), .nop_o(nop_o),
    .plain_o(plain_o), .hint_vld_o(hint_vld_o), .hint_lvl_o(hint_lvl_o));

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got nop/plain/vld/lvl=%b expected %b", tag, act, exp);
    end
  endtask

  // Present one instruction, then sample the registered result.
  task automatic issue(input string tag, input logic [1:0] k, input logic rec,
                       input logic [4:0] rt, input logic [4:0] ra, input logic [4:0] rb,
                       input logic [15:0] imm, input logic um,
                       input logic e_nop, input logic e_plain, input logic e_vld,
                       input logic [2:0] e_lvl);
    @(negedge clk);
    in_vld = 1'b1; in_kind = k; in_rec = rec; in_rt = rt; in_ra = ra;
    in_rb = rb; in_imm = imm; user_mode = um;
    @(negedge clk);
    in_vld = 1'b0;
    chk(tag, {nop_o, plain_o, hint_vld_o, hint_lvl_o}, {e_nop, e_plain, e_vld, e_lvl});
    if (e_vld) cur_lvl = e_lvl;
  endtask

  task automatic self_move(input string tag, input logic [4:0] r, input logic um,
                           input logic e_vld, input logic [2:0] e_lvl);
    issue(tag, 2'b01, 1'b0, r, r, r, 16'h0, um, 1'b0, !e_vld, e_vld,
          e_vld ? e_lvl : cur_lvl);
  endtask

  task automatic t_reset;
    chk("R1 reset", {nop_o, plain_o, hint_vld_o, hint_lvl_o}, {3'b000, 3'd3});
    @(negedge clk);
    chk("R1 idle", {nop_o, plain_o, hint_vld_o, hint_lvl_o}, {3'b000, 3'd3});
  endtask

  task automatic t_nop;
    issue("R2 nop", 2'b10, 1'b0, 5'd0, 5'd0, 5'd9, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, cur_lvl);
    issue("R2 imm nonzero", 2'b10, 1'b0, 5'd0, 5'd0, 5'd0, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, cur_lvl);
    issue("R2 dst nonzero", 2'b10, 1'b0, 5'd4, 5'd0, 5'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, cur_lvl);
    issue("R2 src nonzero", 2'b10, 1'b0, 5'd0, 5'd2, 5'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, cur_lvl);
  endtask

  task automatic t_user_levels;
    self_move("R3 low", 5'd1, 1'b1, 1'b1, 3'd1);
    @(negedge clk);
    chk("R6 strobe ends, level held", {nop_o, plain_o, hint_vld_o, hint_lvl_o}, {3'b000, 3'd1});
    self_move("R4 medium-low", 5'd6, 1'b1, 1'b1, 3'd2);
    self_move("R5 normal", 5'd2, 1'b0, 1'b1, 3'd3);
    self_move("R3 low again", 5'd1, 1'b0, 1'b1, 3'd1);
  endtask

  task automatic t_kernel;
    self_move("R7 r5 user dropped", 5'd5, 1'b1, 1'b0, 3'd0);
    self_move("R7 r3 user dropped", 5'd3, 1'b1, 1'b0, 3'd0);
    self_move("R7 r7 user dropped", 5'd7, 1'b1, 1'b0, 3'd0);
    self_move("R7 r5 kernel", 5'd5, 1'b0, 1'b1, 3'd4);
    self_move("R7 r3 kernel", 5'd3, 1'b0, 1'b1, 3'd5);
    self_move("R7 r7 kernel", 5'd7, 1'b0, 1'b1, 3'd6);
  endtask

  task automatic t_record;
    issue("R8 record r1", 2'b01, 1'b1, 5'd1, 5'd1, 5'd1, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, cur_lvl);
    issue("R8 record r6", 2'b01, 1'b1, 5'd6, 5'd6, 5'd6, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, cur_lvl);
  endtask

  task automatic t_plain;
    self_move("R9 self r0", 5'd0, 1'b0, 1'b0, 3'd0);
    self_move("R9 self r4", 5'd4, 1'b0, 1'b0, 3'd0);
    self_move("R9 self r31", 5'd31, 1'b0, 1'b0, 3'd0);
    issue("R9 rb differs", 2'b01, 1'b0, 5'd1, 5'd1, 5'd2, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, cur_lvl);
    issue("R9 rt differs", 2'b01, 1'b0, 5'd6, 5'd2, 5'd2, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, cur_lvl);
    issue("R9 other kind", 2'b00, 1'b0, 5'd0, 5'd0, 5'd0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, cur_lvl);
    issue("R9 kind 11", 2'b11, 1'b0, 5'd1, 5'd1, 5'd1, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, cur_lvl);
  endtask

  task automatic t_idle;
    @(negedge clk);
    in_kind = 2'b01; in_rt = 5'd1; in_ra = 5'd1; in_rb = 5'd1; in_vld = 1'b0;
    @(negedge clk);
    chk("R10 no valid no result", {nop_o, plain_o, hint_vld_o, hint_lvl_o}, {3'b000, cur_lvl});
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_kind = 2'b00; in_rec = 1'b0;
    in_rt = '0; in_ra = '0; in_rb = '0; in_imm = '0; user_mode = 1'b0;
    cur_lvl = 3'd3;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_nop;
    t_user_levels;
    t_kernel;
    t_record;
    t_plain;
    t_idle;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule